// File: doc/BRIEF.md
# Serial Programming Frame Receiver (Target Side)

This block sits on the target side of a four-wire serial programming link. A host holds the target-reset line low to start a session. It then clocks bytes in on `mosi`, framed by `sck`. The receiver groups those bytes into four-byte command frames. It knows where it is in a frame only by counting bytes, so no byte value marks a frame boundary.

During the third byte of each frame, the block shifts the frame's second byte back out on `miso`. The host uses this echo to confirm that both ends agree on the frame alignment. When the first two bytes of a frame are 0xAC and 0x53, the block raises `prog_en` once the fourth byte has arrived. If the host drops a byte, every later frame is misaligned by one position and the enable is not recognised. Taking target reset inactive and then active again clears the counters and restores alignment.

`sck`, `mosi` and `tgt_rst_n` are sampled with the system clock through a two-flop synchroniser, and edges are detected after synchronisation. Neither side has a stream: bytes arrive at the pace of the external clock, and both outputs are plain level signals, so no valid/ready handshake applies.

Top module: `isp_frame_rx`

## Requirements
- R1: While `tgt_rst_n` is high (session inactive), `miso` is 0 and `prog_en` is 0. Any `sck` or `mosi` activity is ignored and leaves no partial bit or byte count behind.
- R2: Bits are taken from `mosi` on each rising `sck` edge, most significant bit first. Eight rising edges form one byte.
- R3: Bytes are grouped into frames of exactly four by counting alone. Byte positions 0 to 3 repeat without regard to byte values.
- R4: During byte position 2 of a frame, `miso` presents the byte received at position 1, MSB first. Bit 7 is presented before the first rising edge of that byte, and each later bit changes after a falling `sck` edge. During positions 0, 1 and 3, `miso` is 0.
- R5: When a frame's position 0 byte is 0xAC and its position 1 byte is 0x53, `prog_en` rises after the fourth byte of that frame completes, and not earlier. It then stays 1 for the rest of the session, whatever frames follow.
- R6: A frame whose first two bytes are not exactly 0xAC then 0x53 (for example 0xAC 0x35, or 0x53 0xAC) does not set `prog_en`.
- R7: If a byte is dropped, the next frame's first byte is counted as the current frame's fourth byte. The echo then returns the byte in the misaligned position 1, and an enable sequence sent after the drop is not recognised.
- R8: A pulse on `tgt_rst_n` (high, then low again) clears both the byte count and any partial bit count. The next byte is therefore position 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tgt_rst_n | input | 1 | Target reset; low means a programming session is active |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host (echo byte) |
| prog_en | output | 1 | Programming mode enabled |

## Verification
The assertions assume the link is slow compared with the system clock. Each `sck` level must last at least four system clocks, so that a synchronised edge and the byte-done pulse it produces have settled before the opposite edge arrives. The assertions also assume `mosi` is stable around rising `sck` edges. The bench drives every serial level for eight system clocks and changes `mosi` only while `sck` is low. It changes `tgt_rst_n` only while `sck` is low, which keeps every checked cause-and-effect within the window the assertions expect.

// File: rtl/isp_frame_pkg.sv
package isp_frame_pkg;
  parameter int unsigned DEF_BYTE_W      = 8;
  parameter int unsigned DEF_FRAME_BYTES = 4;
  parameter int unsigned DEF_SYNC_STAGES = 2;
  parameter int unsigned DEF_ECHO_SRC    = 1;
  parameter int unsigned DEF_ECHO_POS    = 2;
  parameter logic [7:0]  DEF_EN_B0       = 8'hAC;
  parameter logic [7:0]  DEF_EN_B1       = 8'h53;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/isp_bit_shift.sv
module isp_bit_shift #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW    = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              din,
  output logic [CW-1:0]     bit_cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out
);
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_nxt;

  assign sh_nxt = {sh[BYTE_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      byte_out  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (clr) begin
        sh      <= '0;
        bit_cnt <= '0;
      end else if (rise) begin
        sh <= sh_nxt;
        if (bit_cnt == CW'(BYTE_W - 1)) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          byte_out  <= sh_nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isp_frame_ctl.sv
module isp_frame_ctl #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FRAME_BYTES = 4,
  parameter int unsigned ECHO_SRC    = 1,
  parameter int unsigned ECHO_POS    = 2,
  parameter logic [BYTE_W-1:0] EN_B0 = 8'hAC,
  parameter logic [BYTE_W-1:0] EN_B1 = 8'h53,
  localparam int unsigned IW         = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [IW-1:0]     byte_idx,
  output logic [BYTE_W-1:0] echo_val,
  output logic              echo_load,
  output logic              prog_en
);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);

  logic hdr0_ok, hdr1_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx  <= '0;
      echo_val  <= '0;
      echo_load <= 1'b0;
      hdr0_ok   <= 1'b0;
      hdr1_ok   <= 1'b0;
      prog_en   <= 1'b0;
    end else if (clr) begin
      byte_idx  <= '0;
      echo_load <= 1'b0;
      hdr0_ok   <= 1'b0;
      hdr1_ok   <= 1'b0;
      prog_en   <= 1'b0;
    end else begin
      echo_load <= 1'b0;
      if (byte_done) begin
        byte_idx <= (byte_idx == LAST) ? '0 : byte_idx + 1'b1;
        if (byte_idx == IW'(0))            hdr0_ok   <= (byte_in == EN_B0);
        if (byte_idx == IW'(1))            hdr1_ok   <= (byte_in == EN_B1);
        if (byte_idx == IW'(ECHO_SRC))     echo_val  <= byte_in;
        if (byte_idx == IW'(ECHO_POS - 1)) echo_load <= 1'b1;
        if (byte_idx == LAST && hdr0_ok && hdr1_ok) prog_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isp_echo_tx.sv
module isp_echo_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              win,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  output logic              miso
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sh <= '0;
    else if (clr || !win)  sh <= '0;
    else if (load)         sh <= load_val;
    else if (shift)        sh <= {sh[BYTE_W-2:0], 1'b0};
  end

  assign miso = sh[BYTE_W-1];
endmodule

// File: rtl/isp_frame_rx.sv
module isp_frame_rx
  import isp_frame_pkg::*;
#(
  parameter int unsigned BYTE_W      = DEF_BYTE_W,
  parameter int unsigned FRAME_BYTES = DEF_FRAME_BYTES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned ECHO_SRC    = DEF_ECHO_SRC,
  parameter int unsigned ECHO_POS    = DEF_ECHO_POS,
  parameter logic [BYTE_W-1:0] EN_B0 = DEF_EN_B0,
  parameter logic [BYTE_W-1:0] EN_B1 = DEF_EN_B1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic prog_en
);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam int unsigned IW = $clog2(FRAME_BYTES);

  logic [2:0] raw_in, sync_out;
  logic       sck_s, mosi_s, tgt_rst_s, sck_prev;
  sck_edge_t  edg;
  logic       sess_act, clr;
  logic       sck_fall;

  logic [CW-1:0]     bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [IW-1:0]     byte_idx;
  logic [BYTE_W-1:0] echo_val;
  logic              echo_load;
  logic              echo_win;

  assign raw_in = {tgt_rst_n, mosi, sck};

  isp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign {tgt_rst_s, mosi_s, sck_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign edg.rise = sck_s & ~sck_prev;
  assign edg.fall = ~sck_s & sck_prev;
  assign sck_fall = edg.fall;
  assign sess_act = ~tgt_rst_s;
  assign clr      = ~sess_act;

  isp_bit_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rise(edg.rise), .din(mosi_s),
    .bit_cnt(bit_cnt), .byte_done(byte_done), .byte_out(byte_val)
  );

  isp_frame_ctl #(
    .BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES), .ECHO_SRC(ECHO_SRC),
    .ECHO_POS(ECHO_POS), .EN_B0(EN_B0), .EN_B1(EN_B1)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_done(byte_done),
    .byte_in(byte_val), .byte_idx(byte_idx), .echo_val(echo_val),
    .echo_load(echo_load), .prog_en(prog_en)
  );

  assign echo_win = (byte_idx == IW'(ECHO_POS));

  isp_echo_tx #(.BYTE_W(BYTE_W)) u_echo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .win(echo_win), .load(echo_load),
    .load_val(echo_val), .shift(sck_fall && (bit_cnt != '0)), .miso(miso)
  );
endmodule

// File: rtl/isp_frame_rx_chk.sv
module isp_frame_rx_chk #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FRAME_BYTES = 4,
  parameter int unsigned ECHO_POS    = 2,
  localparam int unsigned CW         = $clog2(BYTE_W),
  localparam int unsigned IW         = $clog2(FRAME_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sess_act,
  input logic          byte_done,
  input logic [IW-1:0] byte_idx,
  input logic [CW-1:0] bit_cnt,
  input logic          sck_fall,
  input logic          echo_load,
  input logic          miso,
  input logic          prog_en
);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);

  // R1: inactive session silences both outputs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_act |=> (!miso && !prog_en));

  // R3: each completed byte advances the frame position by one, wrapping
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_act && byte_done) |=>
      (byte_idx == (($past(byte_idx) == LAST) ? '0 : $past(byte_idx) + 1'b1)));

  // R4: outside the echo position the output is low
  a_r4_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_idx != IW'(ECHO_POS)) |=> !miso);

  // R4: inside the echo byte the output only moves on a load or falling edge
  a_r4_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_act && $past(sess_act) && byte_idx == IW'(ECHO_POS) &&
     $past(byte_idx) == IW'(ECHO_POS) && !$stable(miso))
      |-> ($past(sck_fall) || $past(echo_load)));

  // R5: enable rises only right after a byte completes, and holds in session
  a_r5_rise_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en) |-> $past(byte_done));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && sess_act) |=> prog_en);

  // R8: leaving the session clears both counters
  a_r8_counters_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_act |=> (byte_idx == '0 && bit_cnt == '0));
endmodule

bind isp_frame_rx isp_frame_rx_chk #(
  .BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES), .ECHO_POS(ECHO_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sess_act(sess_act), .byte_done(byte_done),
  .byte_idx(byte_idx), .bit_cnt(bit_cnt), .sck_fall(sck_fall),
  .echo_load(echo_load), .miso(miso), .prog_en(prog_en)
);

// File: tb/isp_frame_rx_tb.sv
module isp_frame_rx_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_rst_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, prog_en;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  isp_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso), .prog_en(prog_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bits_only(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sess_on();
    tgt_rst_n = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic sess_off();
    tgt_rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse();
    sess_off();
    sess_on();
  endtask

  task automatic t_reset_state();
    chk(miso == 1'b0, "R1 miso after reset", miso, 0);
    chk(prog_en == 1'b0, "R1 prog_en after reset", prog_en, 0);
  endtask

  task automatic t_enable();
    logic [7:0] r0, r1, r2, r3, e;
    pulse();
    xfer(8'hAC, r0);
    xfer(8'h53, r1);
    xfer(8'h00, r2);
    chk(prog_en == 1'b0, "R5 not set before fourth byte", prog_en, 0);
    xfer(8'h00, r3);
    chk(r2 == 8'h53, "R4 echo of second byte", r2, 8'h53);
    chk(r0 == 8'h00 && r1 == 8'h00 && r3 == 8'h00, "R4 miso low off echo", {r0, r1, r3}, 0);
    chk(prog_en == 1'b1, "R5 set after enable frame", prog_en, 1);
    xfer(8'h11, r0);
    xfer(8'hC3, r1);
    xfer(8'h00, r2);
    xfer(8'h44, r3);
    chk(r2 == 8'hC3, "R2 MSB-first echo pattern", r2, 8'hC3);
    chk(prog_en == 1'b1, "R5 stays set after other frame", prog_en, 1);
    e = r3;
  endtask

  task automatic t_inactive();
    logic [7:0] r;
    sess_off();
    chk(prog_en == 1'b0, "R1 prog_en cleared when inactive", prog_en, 0);
    xfer(8'hAC, r);
    chk(r == 8'h00, "R1 miso low while inactive", r, 0);
    xfer(8'h53, r);
    xfer(8'h00, r);
    chk(r == 8'h00, "R1 no echo while inactive", r, 0);
    xfer(8'h00, r);
    chk(prog_en == 1'b0, "R1 enable ignored while inactive", prog_en, 0);
    bits_only(3);
    sess_on();
    xfer(8'h20, r);
    xfer(8'h5A, r);
    xfer(8'h00, r);
    chk(r == 8'h5A, "R1 inactive traffic left no count", r, 8'h5A);
    xfer(8'h00, r);
    chk(prog_en == 1'b0, "R6 plain frame does not enable", prog_en, 0);
  endtask

  task automatic t_near_miss();
    logic [7:0] r;
    pulse();
    xfer(8'hAC, r); xfer(8'h35, r); xfer(8'h00, r); xfer(8'h00, r);
    chk(prog_en == 1'b0, "R6 AC 35 does not enable", prog_en, 0);
    xfer(8'h53, r); xfer(8'hAC, r); xfer(8'h00, r); xfer(8'h00, r);
    chk(prog_en == 1'b0, "R6 53 AC does not enable", prog_en, 0);
  endtask

  task automatic t_drop();
    logic [7:0] r;
    pulse();
    xfer(8'hAC, r);
    xfer(8'h00, r);
    chk(r == 8'h00, "R3 position 1 output low", r, 0);
    xfer(8'h00, r);
    chk(r == 8'h00, "R7 echo of dropped-frame byte", r, 0);
    xfer(8'hAC, r);
    xfer(8'h53, r);
    chk(r == 8'h00, "R3 byte counted as position 0", r, 0);
    xfer(8'h00, r);
    xfer(8'h00, r);
    chk(r == 8'h00, "R7 misaligned echo", r, 0);
    chk(prog_en == 1'b0, "R7 enable lost after drop", prog_en, 0);
  endtask

  task automatic t_realign();
    logic [7:0] r;
    pulse();
    xfer(8'hAC, r); xfer(8'h53, r); xfer(8'h00, r);
    chk(r == 8'h53, "R8 echo after reset pulse", r, 8'h53);
    xfer(8'h00, r);
    chk(prog_en == 1'b1, "R8 enable after reset pulse", prog_en, 1);
    pulse();
    bits_only(3);
    pulse();
    xfer(8'hAC, r); xfer(8'h53, r); xfer(8'h00, r);
    chk(r == 8'h53, "R8 partial bits cleared", r, 8'h53);
    xfer(8'h00, r);
    chk(prog_en == 1'b1, "R8 enable after partial byte", prog_en, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_enable();
    t_inactive();
    t_near_miss();
    t_drop();
    t_realign();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule